// File: doc/BRIEF.md
# Single-Buffer Serial Port Status and Interrupt Logic

This block holds the status flags and drives the interrupt requests of a serial port that has a one-byte transmit holding register and a one-byte receive holding register. It takes register access strobes from the bus side and byte-level events from the bit shifters: a transmit byte finished, a receive byte finished (with its parity-error and multiprocessor bits), and a received break. It tells the transmit shifter when to take the next byte, and it tells the receive path when the new byte may go into the receive holding register.

Flags that report errors or buffer state are cleared by software only in two steps. Software first reads the status register and sees a 1. It then writes a 0 to that bit. A parameter selects one of two variants. In the basic variant, software hands over a byte by clearing the transmit-empty flag, and the receive-full and transmit-empty requests are levels. In the enhanced variant, a write to the transmit data register hands over the byte, reading the receive data register clears receive-full, and those two requests are one-cycle pulses.

Top module: `uart_sbuf_status`

## Requirements
- R1: The status byte is laid out as bit7 TDRE (transmit buffer empty), bit6 RDRF (receive buffer full), bit5 ORER (overrun), bit4 FER (framing/break), bit3 PER (parity), bit2 TEND (transmit end), bit1 MPB (received multiprocessor bit), bit0 MPBT (multiprocessor bit to send). After reset it reads 0x84 and every interrupt line is low while its enable is low.
- R2: A status write clears a writable flag only where the written bit is 0 and the most recent status read, with no status write since, showed that bit as 1. A status write without such a read leaves the flags unchanged.
- R3: MPB and TEND never change on a status write. In the enhanced variant RDRF and TDRE don't change on a status write either. MPBT takes bit 0 of every status write.
- R4: A receive completion while RDRF is 0 pulses rx_load in the same cycle and, from the next cycle, sets RDRF, loads MPB from rx_mpb and sets PER if rx_perr. A completion while RDRF is 1 sets ORER, gives no rx_load and leaves MPB and PER unchanged.
- R5: A received break sets FER.
- R6: irq_eri is high exactly while RIE is 1 and at least one of PER, FER or ORER is set.
- R7: In the basic variant irq_rxi = RIE and RDRF, irq_txi = TIE and TDRE, and irq_tei = TEIE and TEND, all as levels. In the enhanced variant irq_tei is the same level. irq_rxi is a one-cycle pulse when RDRF becomes set while RIE is 1. irq_txi is a one-cycle pulse when a byte moves to the shifter or TE is written while TIE is 1. A receive data read clears RDRF.
- R8: A control write that sets TE forces TDRE and TEND to 1.
- R9: The transmitter takes a byte through a hand-over. In the basic variant this is a status write that clears TDRE after TDRE was read as 1. In the enhanced variant it is a transmit data write. If TEND is 1, with no error flag set in the basic case, tx_start pulses in that cycle, TDRE is 1 and TEND is 0. Otherwise TDRE becomes 0. A transmit data write has no effect in the basic variant.
- R10: When the shifter finishes a byte and TDRE is 0, tx_start pulses, TDRE returns to 1 and TEND stays 0. When TDRE is 1, TEND becomes 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| stat_rd | input | 1 | Status register read strobe |
| stat_wr | input | 1 | Status register write strobe |
| wr_data | input | 8 | Status write data |
| data_rd | input | 1 | Receive data register read strobe |
| tdr_wr | input | 1 | Transmit data register write strobe |
| te_wr | input | 1 | Control write with transmit enable set |
| rie | input | 1 | Receive interrupt enable |
| tie | input | 1 | Transmit-empty interrupt enable |
| teie | input | 1 | Transmit-end interrupt enable |
| rx_done | input | 1 | Receive shifter finished a byte |
| rx_mpb | input | 1 | Multiprocessor bit of the finished byte |
| rx_perr | input | 1 | Parity error on the finished byte |
| rx_break | input | 1 | Break detected on the line |
| tx_done | input | 1 | Transmit shifter finished a byte |
| status | output | 8 | Status flags |
| tx_start | output | 1 | Shifter takes the holding byte this cycle |
| rx_load | output | 1 | Received byte goes into the holding register this cycle |
| irq_eri | output | 1 | Receive error request |
| irq_rxi | output | 1 | Receive full request |
| irq_txi | output | 1 | Transmit empty request |
| irq_tei | output | 1 | Transmit end request |

## Verification
The assertions assume that tx_done arrives only while the shifter holds a byte, that is after a tx_start and before TEND is set again. They also assume that tx_done does not coincide with a hand-over in the same cycle. The overrun property ignores cycles in which a status write or data read could empty the receive buffer together with the completion. The stimulus raises one strobe per cycle and reports a shifter finish only after a started byte, so it stays inside these limits.

// File: rtl/uart_sbuf_pkg.sv
package uart_sbuf_pkg;
  localparam int STAT_W = 8;
  localparam int B_MPBT = 0;
  localparam int B_MPB  = 1;
  localparam int B_TEND = 2;
  localparam int B_PER  = 3;
  localparam int B_FER  = 4;
  localparam int B_ORER = 5;
  localparam int B_RDRF = 6;
  localparam int B_TDRE = 7;
  localparam logic [STAT_W-1:0] STAT_RST = 8'h84;

  // flags a status write may clear, per variant
  function automatic logic [STAT_W-1:0] clr_mask(input bit enh);
    logic [STAT_W-1:0] m;
    m = '0;
    m[B_PER]  = 1'b1;
    m[B_FER]  = 1'b1;
    m[B_ORER] = 1'b1;
    if (!enh) begin
      m[B_RDRF] = 1'b1;
      m[B_TDRE] = 1'b1;
    end
    return m;
  endfunction
endpackage

// File: rtl/uart_sbuf_shadow.sv
module uart_sbuf_shadow
  import uart_sbuf_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              stat_rd,
  input  logic              stat_wr,
  input  logic [STAT_W-1:0] stat_q,
  output logic [STAT_W-1:0] seen_q
);
  logic [STAT_W-1:0] seen_d;
  logic              seen_en;

  always_comb begin
    seen_en = stat_rd | stat_wr;
    seen_d  = stat_rd ? stat_q : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       seen_q <= '0;
    else if (seen_en) seen_q <= seen_d;
  end
endmodule

// File: rtl/uart_sbuf_flags.sv
module uart_sbuf_flags
  import uart_sbuf_pkg::*;
#(
  parameter bit ENHANCED = 1'b0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              stat_wr,
  input  logic [STAT_W-1:0] wr_data,
  input  logic [STAT_W-1:0] seen_q,
  input  logic              data_rd,
  input  logic              tdr_wr,
  input  logic              te_wr,
  input  logic              rx_done,
  input  logic              rx_mpb,
  input  logic              rx_perr,
  input  logic              rx_break,
  input  logic              tx_done,
  output logic [STAT_W-1:0] stat_q,
  output logic              tx_start,
  output logic              rx_load,
  output logic              rdrf_rise,
  output logic              txi_evt
);
  localparam logic [STAT_W-1:0] CLR_M = clr_mask(ENHANCED);

  logic [STAT_W-1:0] s;
  logic [STAT_W-1:0] clr;
  logic              hand_over;
  logic              any_err;
  logic              stat_en;

  always_comb begin
    s        = stat_q;
    tx_start = 1'b0;
    rx_load  = 1'b0;
    clr      = stat_wr ? (~wr_data & seen_q & CLR_M) : '0;
    s        = s & ~clr;
    if (stat_wr) s[B_MPBT] = wr_data[B_MPBT];
    if (ENHANCED && data_rd) s[B_RDRF] = 1'b0;
    any_err  = s[B_PER] | s[B_FER] | s[B_ORER];

    // shifter finished a byte
    if (tx_done) begin
      if (!s[B_TDRE]) begin
        tx_start  = 1'b1;
        s[B_TDRE] = 1'b1;
        s[B_TEND] = 1'b0;
      end else begin
        s[B_TEND] = 1'b1;
      end
    end

    // software hands a byte over
    hand_over = ENHANCED ? tdr_wr : clr[B_TDRE];
    if (hand_over) begin
      if (s[B_TEND] && (ENHANCED || !any_err)) begin
        tx_start  = 1'b1;
        s[B_TDRE] = 1'b1;
        s[B_TEND] = 1'b0;
      end else begin
        s[B_TDRE] = 1'b0;
      end
    end

    // receive side
    if (rx_done) begin
      if (s[B_RDRF]) begin
        s[B_ORER] = 1'b1;
      end else begin
        rx_load   = 1'b1;
        s[B_RDRF] = 1'b1;
        s[B_MPB]  = rx_mpb;
        s[B_PER]  = s[B_PER] | rx_perr;
      end
    end
    if (rx_break) s[B_FER] = 1'b1;

    if (te_wr) begin
      s[B_TDRE] = 1'b1;
      s[B_TEND] = 1'b1;
    end

    rdrf_rise = s[B_RDRF] & ~stat_q[B_RDRF];
    txi_evt   = tx_start | te_wr;
    stat_en   = stat_wr | data_rd | tdr_wr | te_wr | rx_done | rx_break | tx_done;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       stat_q <= STAT_RST;
    else if (stat_en) stat_q <= s;
  end
endmodule

// File: rtl/uart_sbuf_irq.sv
module uart_sbuf_irq #(
  parameter bit ENHANCED = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic rie,
  input  logic tie,
  input  logic teie,
  input  logic f_per,
  input  logic f_fer,
  input  logic f_orer,
  input  logic f_rdrf,
  input  logic f_tdre,
  input  logic f_tend,
  input  logic rdrf_rise,
  input  logic txi_evt,
  output logic irq_eri,
  output logic irq_rxi,
  output logic irq_txi,
  output logic irq_tei
);
  logic rxi_p_q;
  logic txi_p_q;
  logic rxi_p_d;
  logic txi_p_d;

  always_comb begin
    rxi_p_d = rie & rdrf_rise;
    txi_p_d = tie & txi_evt;
    irq_eri = rie & (f_per | f_fer | f_orer);
    irq_tei = teie & f_tend;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rxi_p_q <= 1'b0;
      txi_p_q <= 1'b0;
    end else begin
      rxi_p_q <= rxi_p_d;
      txi_p_q <= txi_p_d;
    end
  end

  generate
    if (ENHANCED) begin : g_pulse
      assign irq_rxi = rxi_p_q;
      assign irq_txi = txi_p_q;
    end else begin : g_level
      assign irq_rxi = rie & f_rdrf;
      assign irq_txi = tie & f_tdre;
    end
  endgenerate
endmodule

// File: rtl/uart_sbuf_status.sv
module uart_sbuf_status
  import uart_sbuf_pkg::*;
#(
  parameter bit ENHANCED = 1'b0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              stat_rd,
  input  logic              stat_wr,
  input  logic [STAT_W-1:0] wr_data,
  input  logic              data_rd,
  input  logic              tdr_wr,
  input  logic              te_wr,
  input  logic              rie,
  input  logic              tie,
  input  logic              teie,
  input  logic              rx_done,
  input  logic              rx_mpb,
  input  logic              rx_perr,
  input  logic              rx_break,
  input  logic              tx_done,
  output logic [STAT_W-1:0] status,
  output logic              tx_start,
  output logic              rx_load,
  output logic              irq_eri,
  output logic              irq_rxi,
  output logic              irq_txi,
  output logic              irq_tei
);
  logic [STAT_W-1:0] stat_q;
  logic [STAT_W-1:0] seen_q;
  logic              rdrf_rise;
  logic              txi_evt;

  uart_sbuf_shadow u_shadow (
    .clk     (clk),
    .rst_n   (rst_n),
    .stat_rd (stat_rd),
    .stat_wr (stat_wr),
    .stat_q  (stat_q),
    .seen_q  (seen_q)
  );

  uart_sbuf_flags #(.ENHANCED(ENHANCED)) u_flags (
    .clk       (clk),
    .rst_n     (rst_n),
    .stat_wr   (stat_wr),
    .wr_data   (wr_data),
    .seen_q    (seen_q),
    .data_rd   (data_rd),
    .tdr_wr    (tdr_wr),
    .te_wr     (te_wr),
    .rx_done   (rx_done),
    .rx_mpb    (rx_mpb),
    .rx_perr   (rx_perr),
    .rx_break  (rx_break),
    .tx_done   (tx_done),
    .stat_q    (stat_q),
    .tx_start  (tx_start),
    .rx_load   (rx_load),
    .rdrf_rise (rdrf_rise),
    .txi_evt   (txi_evt)
  );

  uart_sbuf_irq #(.ENHANCED(ENHANCED)) u_irq (
    .clk       (clk),
    .rst_n     (rst_n),
    .rie       (rie),
    .tie       (tie),
    .teie      (teie),
    .f_per     (stat_q[B_PER]),
    .f_fer     (stat_q[B_FER]),
    .f_orer    (stat_q[B_ORER]),
    .f_rdrf    (stat_q[B_RDRF]),
    .f_tdre    (stat_q[B_TDRE]),
    .f_tend    (stat_q[B_TEND]),
    .rdrf_rise (rdrf_rise),
    .txi_evt   (txi_evt),
    .irq_eri   (irq_eri),
    .irq_rxi   (irq_rxi),
    .irq_txi   (irq_txi),
    .irq_tei   (irq_tei)
  );

  assign status = stat_q;
endmodule

// File: rtl/uart_sbuf_chk.sv
module uart_sbuf_chk #(
  parameter bit ENHANCED = 1'b0
) (
  input logic       clk,
  input logic       rst_n,
  input logic       stat_wr,
  input logic [7:0] wr_data,
  input logic       data_rd,
  input logic       te_wr,
  input logic       rx_done,
  input logic [7:0] status,
  input logic       tx_start,
  input logic       rx_load,
  input logic       irq_rxi
);
  AST_OVERRUN_SETS_ORER: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_done && status[6] && !stat_wr && !data_rd) |=> status[5]); // R4

  AST_LOAD_SETS_RDRF: assert property (@(posedge clk) disable iff (!rst_n)
    rx_load |=> status[6]); // R4

  AST_ORER_CLEAR_BY_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(status[5]) |-> $past(stat_wr)); // R2

  AST_MPBT_COPY: assert property (@(posedge clk) disable iff (!rst_n)
    stat_wr |=> (status[0] == $past(wr_data[0]))); // R3

  AST_TE_FORCES_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    te_wr |=> (status[7] && status[2])); // R8

  AST_START_CLEARS_TEND: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_start && !te_wr) |=> (status[7] && !status[2])); // R9

  generate
    if (ENHANCED) begin : g_enh
      AST_RXI_SINGLE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        irq_rxi |=> !irq_rxi); // R7
    end
  endgenerate
endmodule

bind uart_sbuf_status uart_sbuf_chk #(.ENHANCED(ENHANCED)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .stat_wr  (stat_wr),
  .wr_data  (wr_data),
  .data_rd  (data_rd),
  .te_wr    (te_wr),
  .rx_done  (rx_done),
  .status   (status),
  .tx_start (tx_start),
  .rx_load  (rx_load),
  .irq_rxi  (irq_rxi)
);

// File: tb/test_uart_sbuf_status.sv
module test_uart_sbuf_status;
  logic clk;
  logic rst_n;
  logic stat_rd, stat_wr, data_rd, tdr_wr, te_wr;
  logic [7:0] wr_data;
  logic rie, tie, teie;
  logic rx_done, rx_mpb, rx_perr, rx_break, tx_done;

  logic [7:0] st_b, st_e;
  logic start_b, start_e, load_b, load_e;
  logic eri_b, rxi_b, txi_b, tei_b;
  logic eri_e, rxi_e, txi_e, tei_e;

  int n_chk = 0;
  int n_fail = 0;
  logic s_start_b, s_start_e, s_load_b, s_load_e;

  uart_sbuf_status #(.ENHANCED(1'b0)) i_uart_sbuf_status (
    .clk(clk), .rst_n(rst_n), .stat_rd(stat_rd), .stat_wr(stat_wr),
    .wr_data(wr_data), .data_rd(data_rd), .tdr_wr(tdr_wr), .te_wr(te_wr),
    .rie(rie), .tie(tie), .teie(teie), .rx_done(rx_done), .rx_mpb(rx_mpb),
    .rx_perr(rx_perr), .rx_break(rx_break), .tx_done(tx_done),
    .status(st_b), .tx_start(start_b), .rx_load(load_b),
    .irq_eri(eri_b), .irq_rxi(rxi_b), .irq_txi(txi_b), .irq_tei(tei_b));

  uart_sbuf_status #(.ENHANCED(1'b1)) i_uart_sbuf_status_enh (
    .clk(clk), .rst_n(rst_n), .stat_rd(stat_rd), .stat_wr(stat_wr),
    .wr_data(wr_data), .data_rd(data_rd), .tdr_wr(tdr_wr), .te_wr(te_wr),
    .rie(rie), .tie(tie), .teie(teie), .rx_done(rx_done), .rx_mpb(rx_mpb),
    .rx_perr(rx_perr), .rx_break(rx_break), .tx_done(tx_done),
    .status(st_e), .tx_start(start_e), .rx_load(load_e),
    .irq_eri(eri_e), .irq_rxi(rxi_e), .irq_txi(txi_e), .irq_tei(tei_e));

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // one strobe for one cycle; returns at the falling edge after the update
  task automatic fire(input int k, input logic [7:0] d);
    wr_data = d;
    case (k)
      0: stat_rd  = 1'b1;
      1: stat_wr  = 1'b1;
      2: data_rd  = 1'b1;
      3: tdr_wr   = 1'b1;
      4: te_wr    = 1'b1;
      5: rx_done  = 1'b1;
      6: tx_done  = 1'b1;
      default: rx_break = 1'b1;
    endcase
    #1;
    s_start_b = start_b; s_start_e = start_e;
    s_load_b  = load_b;  s_load_e  = load_e;
    @(negedge clk);
    stat_rd = 0; stat_wr = 0; data_rd = 0; tdr_wr = 0; te_wr = 0;
    rx_done = 0; tx_done = 0; rx_break = 0;
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    stat_rd = 0; stat_wr = 0; data_rd = 0; tdr_wr = 0; te_wr = 0;
    rx_done = 0; tx_done = 0; rx_break = 0; rx_mpb = 0; rx_perr = 0;
    wr_data = 8'h00; rie = 0; tie = 0; teie = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic t_reset();
    do_reset();
    chk("R1 reset status basic", st_b, 8'h84);
    chk("R1 reset status enh", st_e, 8'h84);
    chk("R1 reset irqs basic", {4'h0, eri_b, rxi_b, txi_b, tei_b}, 8'h00);
    chk("R1 reset irqs enh", {4'h0, eri_e, rxi_e, txi_e, tei_e}, 8'h00);
  endtask

  task automatic t_receive();
    do_reset();
    rie = 1'b1;
    rx_mpb = 1'b1;
    fire(5, 8'h00);
    chk("R4 load pulse", {6'h0, s_load_b, s_load_e}, 8'h03);
    chk("R4 status after load basic", st_b, 8'hC6);
    chk("R4 status after load enh", st_e, 8'hC6);
    chk("R7 rxi level basic", {7'h0, rxi_b}, 8'h01);
    chk("R7 rxi pulse enh", {7'h0, rxi_e}, 8'h01);
    @(negedge clk);
    chk("R7 rxi pulse ends enh", {7'h0, rxi_e}, 8'h00);
    chk("R7 rxi level holds basic", {7'h0, rxi_b}, 8'h01);
    rx_mpb = 1'b0;
    rx_perr = 1'b1;
    fire(5, 8'h00);
    rx_perr = 1'b0;
    chk("R4 no load on overrun", {6'h0, s_load_b, s_load_e}, 8'h00);
    chk("R4 overrun status basic", st_b, 8'hE6);
    chk("R4 overrun status enh", st_e, 8'hE6);
    chk("R6 eri on overrun", {6'h0, eri_b, eri_e}, 8'h03);
    chk("R7 no rxi pulse on overrun enh", {7'h0, rxi_e}, 8'h00);
  endtask

  task automatic t_clear();
    fire(1, 8'h00);
    chk("R2 write without read basic", st_b, 8'hE6);
    chk("R2 write without read enh", st_e, 8'hE6);
    fire(0, 8'h00);
    fire(1, 8'h81);
    chk("R2 R3 clear after read basic", st_b, 8'h87);
    chk("R3 enh keeps RDRF", st_e, 8'hC7);
    chk("R6 eri cleared", {6'h0, eri_b, eri_e}, 8'h00);
    fire(2, 8'h00);
    chk("R7 data read clears RDRF enh", st_e, 8'h87);
    chk("R7 data read ignored basic", st_b, 8'h87);
  endtask

  task automatic t_break();
    fire(7, 8'h00);
    chk("R5 break sets FER basic", st_b, 8'h97);
    chk("R5 break sets FER enh", st_e, 8'h97);
    chk("R6 eri on FER", {6'h0, eri_b, eri_e}, 8'h03);
    fire(1, 8'h81);
    chk("R2 stale read does not clear", st_b, 8'h97);
    rie = 1'b0;
    #1;
    chk("R6 eri gated by enable", {6'h0, eri_b, eri_e}, 8'h00);
    @(negedge clk);
  endtask

  task automatic t_tx_basic();
    do_reset();
    tie = 1'b1; teie = 1'b1;
    #1;
    chk("R7 txi tei levels basic", {6'h0, txi_b, tei_b}, 8'h03);
    @(negedge clk);
    fire(0, 8'h00);
    fire(1, 8'h7E);
    chk("R9 start pulse basic", {7'h0, s_start_b}, 8'h01);
    chk("R9 status after start basic", st_b, 8'h80);
    chk("R7 tei drops basic", {7'h0, tei_b}, 8'h00);
    chk("R3 enh ignores TDRE write", st_e, 8'h84);
    fire(0, 8'h00);
    fire(1, 8'h7E);
    chk("R9 queued no start basic", {7'h0, s_start_b}, 8'h00);
    chk("R9 queued status basic", st_b, 8'h00);
    chk("R7 txi low basic", {7'h0, txi_b}, 8'h00);
    fire(6, 8'h00);
    chk("R10 next byte start basic", {7'h0, s_start_b}, 8'h01);
    chk("R10 TDRE back basic", st_b, 8'h80);
    fire(6, 8'h00);
    chk("R10 TEND set basic", st_b, 8'h84);
    chk("R7 tei back basic", {7'h0, tei_b}, 8'h01);
  endtask

  task automatic t_tx_blocked();
    do_reset();
    fire(7, 8'h00);
    fire(0, 8'h00);
    fire(1, 8'h7E);
    chk("R9 error blocks start", {7'h0, s_start_b}, 8'h00);
    chk("R9 blocked status", st_b, 8'h14);
    fire(4, 8'h00);
    chk("R8 TE forces empty basic", st_b, 8'h94);
    chk("R8 TE forces empty enh", st_e, 8'h94);
  endtask

  task automatic t_tx_enh();
    do_reset();
    tie = 1'b1;
    fire(3, 8'h00);
    chk("R9 data write start enh", {7'h0, s_start_e}, 8'h01);
    chk("R9 status after start enh", st_e, 8'h80);
    chk("R7 txi pulse enh", {7'h0, txi_e}, 8'h01);
    chk("R9 data write ignored basic", st_b, 8'h84);
    chk("R7 txi level basic", {7'h0, txi_b}, 8'h01);
    @(negedge clk);
    chk("R7 txi pulse ends enh", {7'h0, txi_e}, 8'h00);
    fire(3, 8'h00);
    chk("R9 queued no start enh", {7'h0, s_start_e}, 8'h00);
    chk("R9 queued status enh", st_e, 8'h00);
    fire(6, 8'h00);
    chk("R10 next byte start enh", {7'h0, s_start_e}, 8'h01);
    chk("R10 TDRE back enh", st_e, 8'h80);
    fire(6, 8'h00);
    chk("R10 TEND set enh", st_e, 8'h84);
  endtask

  initial begin
    t_reset();
    t_receive();
    t_clear();
    t_break();
    t_tx_basic();
    t_tx_blocked();
    t_tx_enh();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog actual=%h expected=%h", 8'h01, 8'h00);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule